// File: doc/BRIEF.md
# Shared Register Transfer Bus

This block is the datapath backbone of a small accumulator-style processor. A single 16-bit bus carries one value per cycle. A 3-bit select code picks that value from one of six working registers or from the memory read data. Each register has its own destination controls, and on a clock edge it may take the bus value, step itself by one, or return to zero. The control sequencer and the arithmetic unit sit outside the block. They drive the select code and the per-register controls each cycle.

There are two 12-bit registers: an address register that always supplies the memory address, and a program counter. There are four 16-bit registers: data, accumulator, instruction and scratch. The 12-bit registers appear on the bus with their top four bits forced to zero. When they load, they keep only the low twelve bus bits. The instruction register can only be loaded. Memory is external and presents its read word for the current address in the same cycle.

Top module: `xfer_bus_core`

## Requirements
- R1: Select code 1 puts the address register on the bus. Code 2 selects the program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the scratch register and 7 the memory read data.
- R2: Select code 0 puts all zeros on the bus.
- R3: When a 12-bit register drives the bus, bus bits 15..12 are zero.
- R4: A register whose load bit is high holds the bus value after the next rising clock edge.
- R5: A 12-bit register that loads from the bus keeps only bus bits 11..0.
- R6: A register whose clear bit is high is zero after the next rising clock edge.
- R7: Increment adds one modulo the register width, so a 12-bit register wraps from 0xFFF to 0x000.
- R8: When several controls of one register are high together, clear wins over load, and load wins over increment.
- R9: The instruction register responds only to load. Its increment and clear bits have no effect.
- R10: The memory address output always equals the address register.
- R11: After an active-low reset, every register is zero.
- R12: A register with no control bit high keeps its value.
- R13: Register index in the control vectors: bit 0 address, 1 program counter, 2 data, 3 accumulator, 4 instruction, 5 scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Source select code for the bus |
| reg_ld | input | 6 | Per-register load controls |
| reg_inc | input | 6 | Per-register increment controls |
| reg_clr | input | 6 | Per-register clear controls |
| mem_rdata | input | 16 | Memory word at mem_addr |
| mem_addr | output | 12 | Memory address, driven by the address register |
| bus_out | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Scratch register |

## Verification
A wrong register value shows on that register's output one clock edge after the faulty control. Selecting that register puts the same wrong value on the bus in the same cycle. A wrong address register also changes the memory word that comes back, so every later memory load carries the error. A priority or truncation fault therefore shows one cycle after the stimulus.

// File: rtl/xfer_bus_pkg.sv
package xfer_bus_pkg;

    localparam int NREG      = 6;
    localparam int SEL_W     = 3;
    localparam int IDX_AR    = 0;
    localparam int IDX_PC    = 1;
    localparam int IDX_DR    = 2;
    localparam int IDX_AC    = 3;
    localparam int IDX_IR    = 4;
    localparam int IDX_TR    = 5;
    localparam int SEL_IDLE  = 0;
    localparam int SEL_MEM   = 7;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_STEP  = 2'd3
    } reg_act_e;

    function automatic bit is_narrow(input int idx);
        return (idx == IDX_AR) || (idx == IDX_PC);
    endfunction

    function automatic bit has_step_clear(input int idx);
        return idx != IDX_IR;
    endfunction

endpackage

// File: rtl/xfer_reg.sv
module xfer_reg
    import xfer_bus_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         inc,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    typedef struct packed {
        reg_act_e     act;
        logic [W-1:0] val;
    } reg_state_t;

    reg_state_t st_d;
    logic [W-1:0] val_q;

    always_comb begin
        // clear over load over increment
        if (clr) begin
            st_d.act = ACT_CLEAR;
        end else if (ld) begin
            st_d.act = ACT_LOAD;
        end else if (inc) begin
            st_d.act = ACT_STEP;
        end else begin
            st_d.act = ACT_HOLD;
        end
        unique case (st_d.act)
            ACT_CLEAR: st_d.val = '0;
            ACT_LOAD:  st_d.val = din;
            ACT_STEP:  st_d.val = val_q + W'(1);
            default:   st_d.val = val_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= st_d.val;
        end
    end

    assign q = val_q;

endmodule

// File: rtl/bus_src_mux.sv
module bus_src_mux
    import xfer_bus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] src [NREG],
    input  logic [DATA_W-1:0] mem_word,
    output logic [DATA_W-1:0] bus
);

    always_comb begin
        bus = '0;
        for (int k = 0; k < NREG; k++) begin
            if (sel == SEL_W'(k + 1)) begin
                bus = src[k];
            end
        end
        if (sel == SEL_W'(SEL_MEM)) begin
            bus = mem_word;
        end
    end

endmodule

// File: rtl/xfer_bus_core.sv
module xfer_bus_core
    import xfer_bus_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_sel,
    input  logic [5:0]        reg_ld,
    input  logic [5:0]        reg_inc,
    input  logic [5:0]        reg_clr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] bus_out,
    output logic [ADDR_W-1:0] ar_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [DATA_W-1:0] dr_q,
    output logic [DATA_W-1:0] ac_q,
    output logic [DATA_W-1:0] ir_q,
    output logic [DATA_W-1:0] tr_q
);

    logic [DATA_W-1:0] reg_ext [NREG];
    logic [DATA_W-1:0] bus_d;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam int RW = is_narrow(i) ? ADDR_W : DATA_W;
        localparam bit FULL = has_step_clear(i);
        logic [RW-1:0]     q_w;
        logic [DATA_W-1:0] ext_w;

        xfer_reg #(.W(RW)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (reg_ld[i]),
            .inc   (reg_inc[i] & FULL),
            .clr   (reg_clr[i] & FULL),
            .din   (bus_d[RW-1:0]),
            .q     (q_w)
        );

        // zero-extend narrow registers onto the bus
        always_comb begin
            ext_w = '0;
            ext_w[RW-1:0] = q_w;
        end
        assign reg_ext[i] = ext_w;
    end

    bus_src_mux #(.DATA_W(DATA_W)) u_mux (
        .sel      (bus_sel),
        .src      (reg_ext),
        .mem_word (mem_rdata),
        .bus      (bus_d)
    );

    assign bus_out  = bus_d;
    assign ar_q     = reg_ext[IDX_AR][ADDR_W-1:0];
    assign pc_q     = reg_ext[IDX_PC][ADDR_W-1:0];
    assign dr_q     = reg_ext[IDX_DR];
    assign ac_q     = reg_ext[IDX_AC];
    assign ir_q     = reg_ext[IDX_IR];
    assign tr_q     = reg_ext[IDX_TR];
    assign mem_addr = ar_q;

endmodule

// File: rtl/xfer_bus_chk.sv
module xfer_bus_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_sel,
    input logic [5:0]  reg_ld,
    input logic [5:0]  reg_inc,
    input logic [5:0]  reg_clr,
    input logic [11:0] mem_addr,
    input logic [15:0] bus_out,
    input logic [11:0] ar_q,
    input logic [11:0] pc_q,
    input logic [15:0] dr_q,
    input logic [15:0] ac_q,
    input logic [15:0] ir_q,
    input logic [15:0] tr_q
);

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel == 3'd0 |-> bus_out == 16'h0000); // R2

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 3'd1 || bus_sel == 3'd2) |-> bus_out[15:12] == 4'h0); // R3

    AST_AR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ld[0] && !reg_clr[0]) |=> ar_q == $past(bus_out[11:0])); // R5

    AST_DR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clr[2] |=> dr_q == 16'h0000); // R6

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_inc[1] && !reg_ld[1] && !reg_clr[1]) |=> pc_q == 12'($past(pc_q) + 12'd1)); // R7

    AST_AC_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ld[3] && reg_inc[3] && !reg_clr[3]) |=> ac_q == $past(bus_out)); // R8

    AST_IR_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_ld[4] |=> $stable(ir_q)); // R9

    AST_ADDR_FROM_AR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr == ar_q); // R10

    AST_TR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_ld[5] || reg_inc[5] || reg_clr[5]) |=> $stable(tr_q)); // R12

endmodule

bind xfer_bus_core xfer_bus_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .reg_ld   (reg_ld),
    .reg_inc  (reg_inc),
    .reg_clr  (reg_clr),
    .mem_addr (mem_addr),
    .bus_out  (bus_out),
    .ar_q     (ar_q),
    .pc_q     (pc_q),
    .dr_q     (dr_q),
    .ac_q     (ac_q),
    .ir_q     (ir_q),
    .tr_q     (tr_q)
);

// File: tb/sim_xfer_bus_core.sv
`timescale 1ns/1ps
module sim_xfer_bus_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = 3'd0;
    logic [5:0]  reg_ld = '0;
    logic [5:0]  reg_inc = '0;
    logic [5:0]  reg_clr = '0;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic [15:0] bus_out;
    logic [11:0] ar_q, pc_q;
    logic [15:0] dr_q, ac_q, ir_q, tr_q;

    logic [15:0] mem [4096];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bit positions: 0 AR, 1 PC, 2 DR, 3 AC, 4 IR, 5 TR
    localparam logic [5:0] B_AR = 6'b000001;
    localparam logic [5:0] B_PC = 6'b000010;
    localparam logic [5:0] B_DR = 6'b000100;
    localparam logic [5:0] B_AC = 6'b001000;
    localparam logic [5:0] B_IR = 6'b010000;
    localparam logic [5:0] B_TR = 6'b100000;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    xfer_bus_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
        .reg_ld(reg_ld), .reg_inc(reg_inc), .reg_clr(reg_clr),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .bus_out(bus_out),
        .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q),
        .ir_q(ir_q), .tr_q(tr_q)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive controls for one edge, then sample 1 ns after it
    task automatic step(input logic [2:0] s, input logic [5:0] ld,
                        input logic [5:0] inc, input logic [5:0] clr);
        bus_sel = s; reg_ld = ld; reg_inc = inc; reg_clr = clr;
        @(posedge clk);
        #1;
        reg_ld = '0; reg_inc = '0; reg_clr = '0;
    endtask

    task automatic t_reset;
        check("R11 ar", {4'h0, ar_q}, 16'h0);
        check("R11 pc", {4'h0, pc_q}, 16'h0);
        check("R11 dr", dr_q, 16'h0);
        check("R11 ac", ac_q, 16'h0);
        check("R11 ir", ir_q, 16'h0);
        check("R11 tr", tr_q, 16'h0);
        bus_sel = 3'd0; #1;
        check("R2 idle bus", bus_out, 16'h0);
    endtask

    task automatic t_load;
        step(3'd7, B_AR, '0, '0);
        check("R5 ar truncates", {4'h0, ar_q}, 16'h05C3);
        step(3'd7, B_DR | B_AC | B_IR | B_TR | B_PC, '0, '0);
        check("R4 dr load", dr_q, 16'hBEEF);
        check("R4 ir load", ir_q, 16'hBEEF);
        check("R5 pc truncates", {4'h0, pc_q}, 16'h0EEF);
    endtask

    task automatic t_map;
        step(3'd0, '0, B_DR | B_AC | B_TR | B_IR, '0);
        step(3'd0, '0, B_AC | B_TR | B_IR, '0);
        step(3'd0, '0, B_TR | B_AR, '0);
        check("R9 ir ignores inc", ir_q, 16'hBEEF);
        bus_sel = 3'd1; #1; check("R1 R3 sel1", bus_out, 16'h05C4);
        bus_sel = 3'd2; #1; check("R1 R3 sel2", bus_out, 16'h0EEF);
        bus_sel = 3'd3; #1; check("R1 sel3", bus_out, 16'hBEF0);
        bus_sel = 3'd4; #1; check("R1 sel4", bus_out, 16'hBEF1);
        bus_sel = 3'd5; #1; check("R1 sel5", bus_out, 16'hBEEF);
        bus_sel = 3'd6; #1; check("R1 sel6", bus_out, 16'hBEF2);
        bus_sel = 3'd7; #1; check("R1 sel7", bus_out, 16'h1FFF);
        check("R10 mem addr", {4'h0, mem_addr}, 16'h05C4);
    endtask

    task automatic t_wrap;
        step(3'd7, B_PC, '0, '0);
        check("R5 pc 1FFF", {4'h0, pc_q}, 16'h0FFF);
        step(3'd0, '0, B_PC, '0);
        check("R7 pc wraps", {4'h0, pc_q}, 16'h0000);
    endtask

    task automatic t_priority;
        step(3'd7, B_DR, B_DR, B_DR);
        check("R8 clear wins", dr_q, 16'h0000);
        step(3'd7, B_DR, B_DR, '0);
        check("R8 load over inc", dr_q, 16'h1FFF);
        step(3'd0, '0, B_DR, '0);
        check("R7 dr inc", dr_q, 16'h2000);
        step(3'd0, '0, '0, B_AC);
        check("R6 ac clear", ac_q, 16'h0000);
    endtask

    task automatic t_ir_and_hold;
        step(3'd0, '0, '0, B_IR);
        check("R9 ir ignores clr", ir_q, 16'hBEEF);
        step(3'd3, B_IR, '0, '0);
        check("R4 ir from dr", ir_q, 16'h2000);
        step(3'd7, '0, '0, '0);
        check("R12 tr holds", tr_q, 16'hBEF2);
        check("R12 dr holds", dr_q, 16'h2000);
        check("R13 ar holds", {4'h0, ar_q}, 16'h05C4);
    endtask

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = 16'h0;
        mem[12'h000] = 16'hA5C3;
        mem[12'h5C3] = 16'hBEEF;
        mem[12'h5C4] = 16'h1FFF;
        #1;
        t_reset();
        @(posedge clk); #1;
        rst_n = 1'b1;
        t_load();
        t_map();
        t_wrap();
        t_priority();
        t_ir_and_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule